// File: doc/BRIEF.md
# DMA Channel Completion and Status Control

This block is the per-channel control and status logic of a DMA controller. Software programs it through a small register port. It holds an enable bit, an interrupt-enable bit, a transfer-size code, a chain-mode bit, a down-counting transfer counter and a chain counter. A separate datapath, outside this block, moves the data. That datapath pulses `xferDone` once for each completed transfer. This block decides, cycle by cycle, whether the channel may raise a transfer request.

When the programmed transfers are exhausted, the block sets a sticky completion flag. It drives an interrupt level when interrupts are enabled. In chain mode the transfer counter is reloaded for each link, and completion comes only after the last link.

Early termination never sets the completion flag. Early termination means an abort pulse, the channel enable being written to 0, or the global master enable going low. While the completion flag is set, the channel stays idle. Software can clear the flag only by reading it as 1 and then writing 0 to it. Entering standby also clears the flag, but module standby does not.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, every control field, the transfer counter and the chain counter read 0, and `xferReq` and `irqOut` are 0.
- R2: `xferReq` is 1 exactly when all of the following hold: the enable bit is 1, `masterEn` is 1, the completion flag is 0, the size code is not 11, `modStandby` is 0, the transfer counter is non-zero, and, in chain mode, the chain counter is non-zero.
- R3: Each `xferDone` pulse seen while `xferReq` is 1, with no `abortIn` in the same cycle, lowers the transfer counter by one. A pulse seen while `xferReq` is 0 changes nothing.
- R4: Outside chain mode, the transfer counter reaching 0 sets the completion flag (control bit 2).
- R5: In chain mode, when the counter reaches the end of a link, the counter is reloaded from the last value written to it and the chain counter drops by one. The completion flag is set only when the chain counter reaches 0.
- R6: `irqOut` is a level equal to the completion flag AND the interrupt-enable bit. It falls as soon as either bit is cleared.
- R7: An `abortIn` pulse clears the enable bit and leaves the counter and the completion flag unchanged. Writing the enable bit to 0, or dropping `masterEn`, also stops the countdown without setting the flag.
- R8: The completion flag is cleared only by a control write with bit 2 = 0 that follows a control read which returned bit 2 = 1. Any control write consumes that read. A write of 1 to bit 2 never sets the flag, and a write of 0 with no prior read leaves it set.
- R9: A `standbyIn` pulse clears the completion flag and the pending read. `modStandby` only blocks requests; the flag and all registers keep their values.
- R10: The size code 11 is stored and read back unchanged, but it suppresses `xferReq`.
- R11: Register map by `regAddr`:
  - Address 0 is the control register: bit 0 enable, bit 1 interrupt enable, bit 2 completion flag, bits 5:4 size (00 byte, 01 word, 10 longword, 11 invalid), bit 6 chain mode.
  - Address 1 is the transfer counter. A write to it also sets the reload value.
  - Address 2 is the chain counter.
  - Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr |
| xferDone | input | 1 | One transfer completed |
| abortIn | input | 1 | Abort pulse (exception or error) |
| masterEn | input | 1 | Global DMA enable level |
| standbyIn | input | 1 | Standby entry pulse |
| modStandby | input | 1 | Module standby level |
| xferReq | output | 1 | Channel may request a transfer |
| irqOut | output | 1 | Completion interrupt level |

## Verification
The assertions assume that a register write and an `xferDone` pulse never occur in the same cycle. They also assume that a read and a write do not coincide. Given those limits, they take a counter step as a clean decrement. The random stimulus issues one operation per cycle (a single read, write, pulse or level change), so these collisions never arise. Counter values are kept small so that link ends and completions happen often.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  localparam int EN_BIT    = 0;
  localparam int IE_BIT    = 1;
  localparam int DONE_BIT  = 2;
  localparam int SIZE_LO   = 4;
  localparam int CHAIN_BIT = 6;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_COUNT = 1;
  localparam int ADDR_CHAIN = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } xferSize_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrCount;
    logic wrChain;
    logic decCount;
    logic reloadCount;
    logic decChain;
    logic setDone;
    logic clrDone;
    logic clrEn;
    logic arm;
    logic disarm;
  } strobe_t;

  typedef struct packed {
    logic      chanEn;
    logic      irqEn;
    logic      done;
    logic      chainMode;
    logic      armed;
    logic      countZero;
    logic      countOne;
    logic      chainZero;
    logic      chainOne;
    xferSize_e size;
  } status_t;
endpackage

// File: rtl/dma_chan_dp.sv
`timescale 1ns/1ps
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CHAIN_W = 8,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output status_t           stat,
  output logic [DATA_W-1:0] regRdata
);
  logic              chanEnQ, irqEnQ, doneQ, chainModeQ, armedQ;
  xferSize_e         sizeQ;
  logic [CNT_W-1:0]  countQ, reloadQ;
  logic [CHAIN_W-1:0] chainQ;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEnQ    <= 1'b0;
      irqEnQ     <= 1'b0;
      doneQ      <= 1'b0;
      chainModeQ <= 1'b0;
      armedQ     <= 1'b0;
      sizeQ      <= SZ_BYTE;
      countQ     <= '0;
      reloadQ    <= '0;
      chainQ     <= '0;
    end else begin
      if (stb.wrCtrl) begin
        chanEnQ    <= regWdata[EN_BIT];
        irqEnQ     <= regWdata[IE_BIT];
        chainModeQ <= regWdata[CHAIN_BIT];
        sizeQ      <= xferSize_e'(regWdata[SIZE_LO+1:SIZE_LO]);
      end
      if (stb.clrEn) chanEnQ <= 1'b0;

      if (stb.clrDone)      doneQ <= 1'b0;
      else if (stb.setDone) doneQ <= 1'b1;

      if (stb.disarm) armedQ <= 1'b0;
      if (stb.arm)    armedQ <= 1'b1;

      if (stb.wrCount) begin
        countQ  <= regWdata[CNT_W-1:0];
        reloadQ <= regWdata[CNT_W-1:0];
      end else if (stb.reloadCount) begin
        countQ <= reloadQ;
      end else if (stb.decCount) begin
        countQ <= countQ - CNT_W'(1);
      end

      if (stb.wrChain)       chainQ <= regWdata[CHAIN_W-1:0];
      else if (stb.decChain) chainQ <= chainQ - CHAIN_W'(1);
    end
  end

  always_comb begin
    stat.chanEn    = chanEnQ;
    stat.irqEn     = irqEnQ;
    stat.done      = doneQ;
    stat.chainMode = chainModeQ;
    stat.armed     = armedQ;
    stat.size      = sizeQ;
    stat.countZero = (countQ == '0);
    stat.countOne  = (countQ == CNT_W'(1));
    stat.chainZero = (chainQ == '0);
    stat.chainOne  = (chainQ == CHAIN_W'(1));
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      regRdata[EN_BIT]               = chanEnQ;
      regRdata[IE_BIT]               = irqEnQ;
      regRdata[DONE_BIT]             = doneQ;
      regRdata[SIZE_LO+1:SIZE_LO]    = sizeQ;
      regRdata[CHAIN_BIT]            = chainModeQ;
    end else if (regAddr == ADDR_W'(ADDR_COUNT)) begin
      regRdata[CNT_W-1:0] = countQ;
    end else if (regAddr == ADDR_W'(ADDR_CHAIN)) begin
      regRdata[CHAIN_W-1:0] = chainQ;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  status_t           stat,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrDoneBit,
  input  logic              xferDone,
  input  logic              abortIn,
  input  logic              masterEn,
  input  logic              standbyIn,
  input  logic              modStandby,
  output strobe_t           stb,
  output logic              xferReq,
  output logic              irqOut
);
  logic active, step, linkEnd, ctrlSel, ctrlWr, sizeOk, chainOk;

  assign sizeOk  = (stat.size != SZ_BAD);
  assign chainOk = !stat.chainMode || !stat.chainZero;
  assign active  = stat.chanEn && masterEn && !stat.done && sizeOk &&
                   !modStandby && !stat.countZero && chainOk;
  assign step    = xferDone && active && !abortIn;
  assign linkEnd = step && stat.countOne;
  assign ctrlSel = (regAddr == ADDR_W'(ADDR_CTRL));
  assign ctrlWr  = regWe && ctrlSel;

  always_comb begin
    stb             = '0;
    stb.wrCtrl      = ctrlWr;
    stb.wrCount     = regWe && (regAddr == ADDR_W'(ADDR_COUNT));
    stb.wrChain     = regWe && (regAddr == ADDR_W'(ADDR_CHAIN));
    stb.decCount    = step;
    stb.reloadCount = linkEnd && stat.chainMode && !stat.chainOne;
    stb.decChain    = linkEnd && stat.chainMode;
    stb.setDone     = linkEnd && (!stat.chainMode || stat.chainOne);
    stb.clrDone     = standbyIn || (ctrlWr && stat.armed && !wrDoneBit);
    stb.clrEn       = abortIn;
    stb.disarm      = ctrlWr || standbyIn;
    stb.arm         = regRe && ctrlSel && stat.done && !stb.clrDone;
  end

  assign xferReq = active;
  assign irqOut  = stat.done && stat.irqEn;
endmodule

// File: rtl/dma_chan_status.sv
`timescale 1ns/1ps
module dma_chan_status
  import dma_chan_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CHAIN_W = 8,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              xferDone,
  input  logic              abortIn,
  input  logic              masterEn,
  input  logic              standbyIn,
  input  logic              modStandby,
  output logic              xferReq,
  output logic              irqOut
);
  strobe_t stb;
  status_t stat;

  dma_chan_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .stat(stat), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .wrDoneBit(regWdata[DONE_BIT]), .xferDone(xferDone), .abortIn(abortIn),
    .masterEn(masterEn), .standbyIn(standbyIn), .modStandby(modStandby),
    .stb(stb), .xferReq(xferReq), .irqOut(irqOut)
  );

  dma_chan_dp #(.CNT_W(CNT_W), .CHAIN_W(CHAIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .regWdata(regWdata),
    .stat(stat), .regRdata(regRdata)
  );
endmodule

// File: rtl/dma_chan_status_chk.sv
`timescale 1ns/1ps
module dma_chan_status_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferReq,
  input logic              irqOut,
  input logic              xferDone,
  input logic              abortIn,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrDoneBit,
  input logic              standbyIn,
  input logic              modStandby,
  input logic              doneQ,
  input logic [CNT_W-1:0]  countQ
);
  // R2: a set completion flag keeps the channel idle
  p_done_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !xferReq);

  // R9: module standby blocks requests
  p_modstby_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    modStandby |-> !xferReq);

  // R6: no interrupt without the flag
  p_irq_needs_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !doneQ |-> !irqOut);

  // R3: accepted completion pulse lowers the counter by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferDone && !abortIn && !regWe && countQ > CNT_W'(1))
      |=> countQ == $past(countQ) - CNT_W'(1));

  // R7: an abort never sets the flag
  p_abort_no_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (abortIn && !doneQ) |=> !doneQ);

  // R8: the flag holds unless standby or a zero write to the control word
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !standbyIn && !(regWe && regAddr == '0 && !wrDoneBit)) |=> doneQ);

  // R9: standby entry clears the flag
  p_standby_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    standbyIn |=> !doneQ);
endmodule

bind dma_chan_status dma_chan_status_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .xferReq(xferReq), .irqOut(irqOut), .xferDone(xferDone),
  .abortIn(abortIn), .regWe(regWe), .regAddr(regAddr),
  .wrDoneBit(regWdata[dma_chan_pkg::DONE_BIT]), .standbyIn(standbyIn),
  .modStandby(modStandby), .doneQ(stat.done), .countQ(u_dp.countQ)
);

// File: tb/test_dma_chan_status.sv
`timescale 1ns/1ps
module test_dma_chan_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        xferDone = 1'b0, abortIn = 1'b0, masterEn = 1'b1;
  logic        standbyIn = 1'b0, modStandby = 1'b0;
  logic        xferReq, irqOut;

  int vectors = 0;
  int fails = 0;

  // bench model of the requirements
  logic        mEn = 0, mIe = 0, mDone = 0, mChainMode = 0, mArmed = 0;
  logic [1:0]  mSize = 0;
  logic [15:0] mCount = 0, mReload = 0;
  logic [7:0]  mChain = 0;

  always #2.5 clk = ~clk;

  dma_chan_status i_dma_chan_status (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .xferDone(xferDone), .abortIn(abortIn),
    .masterEn(masterEn), .standbyIn(standbyIn), .modStandby(modStandby),
    .xferReq(xferReq), .irqOut(irqOut)
  );

  function automatic logic expReq();
    return mEn && masterEn && !mDone && mSize != 2'b11 && !modStandby &&
           mCount != 0 && (!mChainMode || mChain != 0);
  endfunction

  function automatic logic [31:0] ctrlWord(logic en, logic ie, logic dn, logic [1:0] sz, logic ch);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = ie; w[2] = dn; w[5:4] = sz; w[6] = ch;
    return w;
  endfunction

  function automatic logic [31:0] expRead(logic [1:0] a);
    case (a)
      2'd0: return ctrlWord(mEn, mIe, mDone, mSize, mChainMode);
      2'd1: return {16'd0, mCount};
      2'd2: return {24'd0, mChain};
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkOuts(string req);
    check({req, " xferReq"}, {31'd0, xferReq}, {31'd0, expReq()});
    check({req, " irqOut"},  {31'd0, irqOut},  {31'd0, mDone & mIe});
  endtask

  task automatic doWrite(logic [1:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    case (a)
      2'd0: begin
        if (mArmed && !d[2]) mDone = 0;
        mArmed = 0;
        mEn = d[0]; mIe = d[1]; mSize = d[5:4]; mChainMode = d[6];
      end
      2'd1: begin mCount = d[15:0]; mReload = d[15:0]; end
      2'd2: mChain = d[7:0];
      default: ;
    endcase
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic doRead(logic [1:0] a, output logic [31:0] rd);
    regRe = 1'b1; regAddr = a;
    #1 rd = regRdata;
    if (a == 2'd0 && mDone) mArmed = 1;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic doPulse(logic ab);
    logic step;
    step = expReq() && !ab;
    xferDone = 1'b1; abortIn = ab;
    if (ab) mEn = 0;
    if (step) begin
      if (mCount == 1) begin
        if (mChainMode && mChain != 1) begin
          mCount = mReload; mChain = mChain - 1;
        end else begin
          mCount = 0; mDone = 1;
          if (mChainMode) mChain = 0;
        end
      end else mCount = mCount - 1;
    end
    @(negedge clk);
    xferDone = 1'b0; abortIn = 1'b0;
  endtask

  task automatic doStandby();
    standbyIn = 1'b1; mDone = 0; mArmed = 0;
    @(negedge clk);
    standbyIn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    doRead(2'd0, rd); check("R1 ctrl", rd, 32'h0);
    doRead(2'd1, rd); check("R1 count", rd, 32'h0);
    doRead(2'd2, rd); check("R1 chain", rd, 32'h0);
    checkOuts("R1");

    // R2 R3 R4: normal completion, interrupts off
    doWrite(2'd1, 32'd3);
    doWrite(2'd0, ctrlWord(1, 0, 0, 2'b01, 0));
    check("R2 req on", {31'd0, xferReq}, 32'd1);
    doPulse(0); doPulse(0);
    doRead(2'd1, rd); check("R3 count after two", rd, 32'd1);
    // R3 pulse ignored while idle is covered below; finish now
    doPulse(0);
    check("R4 req off at end", {31'd0, xferReq}, 32'd0);
    check("R6 no irq when disabled", {31'd0, irqOut}, 32'd0);

    // R8: zero write without read keeps flag; irq shows it (R6)
    doWrite(2'd0, ctrlWord(1, 1, 0, 2'b01, 0));
    check("R8 flag kept (irq)", {31'd0, irqOut}, 32'd1);
    check("R2 flag blocks enabled channel", {31'd0, xferReq}, 32'd0);
    doPulse(0);
    doRead(2'd1, rd); check("R3 pulse ignored when idle", rd, 32'd0);
    doRead(2'd0, rd); check("R4 flag read", {31'd0, rd[2]}, 32'd1);
    doWrite(2'd0, ctrlWord(1, 1, 1, 2'b01, 0));
    check("R8 read consumed by write of one", {31'd0, irqOut}, 32'd1);
    doWrite(2'd0, ctrlWord(1, 1, 0, 2'b01, 0));
    check("R8 zero write after consumed read", {31'd0, irqOut}, 32'd1);
    doRead(2'd0, rd);
    doWrite(2'd0, ctrlWord(0, 1, 0, 2'b01, 0));
    check("R8 cleared after read", {31'd0, irqOut}, 32'd0);
    doRead(2'd0, rd); check("R8 flag clear", {31'd0, rd[2]}, 32'd0);

    // R7 abort causes
    doWrite(2'd1, 32'd5);
    doWrite(2'd0, ctrlWord(1, 1, 0, 2'b10, 0));
    doPulse(0);
    doPulse(1);
    doRead(2'd1, rd); check("R7 abort keeps count", rd, 32'd4);
    doRead(2'd0, rd); check("R7 abort clears enable, no flag", rd, ctrlWord(0, 1, 0, 2'b10, 0));
    doWrite(2'd0, ctrlWord(1, 1, 0, 2'b10, 0));
    masterEn = 1'b0; @(negedge clk);
    check("R7 master off no req", {31'd0, xferReq}, 32'd0);
    doPulse(0);
    doRead(2'd1, rd); check("R7 master off count held", rd, 32'd4);
    masterEn = 1'b1; @(negedge clk);
    doWrite(2'd0, ctrlWord(0, 1, 0, 2'b10, 0));
    doPulse(0);
    doRead(2'd1, rd); check("R7 disabled count held", rd, 32'd4);
    check("R7 no irq after stops", {31'd0, irqOut}, 32'd0);

    // R9 module standby vs standby entry
    doWrite(2'd1, 32'd1);
    doWrite(2'd0, ctrlWord(1, 1, 0, 2'b00, 0));
    doPulse(0);
    modStandby = 1'b1; @(negedge clk);
    doRead(2'd0, rd); check("R9 module standby keeps flag", rd, ctrlWord(1, 1, 1, 2'b00, 0));
    check("R9 irq held", {31'd0, irqOut}, 32'd1);
    modStandby = 1'b0; @(negedge clk);
    doStandby();
    check("R9 standby clears flag", {31'd0, irqOut}, 32'd0);
    doWrite(2'd1, 32'd2);
    modStandby = 1'b1; @(negedge clk);
    check("R9 module standby blocks req", {31'd0, xferReq}, 32'd0);
    modStandby = 1'b0; @(negedge clk);
    check("R9 req back", {31'd0, xferReq}, 32'd1);

    // R10 invalid size
    doWrite(2'd0, ctrlWord(1, 0, 0, 2'b11, 0));
    doRead(2'd0, rd); check("R10 size stored", rd, ctrlWord(1, 0, 0, 2'b11, 0));
    check("R10 no req", {31'd0, xferReq}, 32'd0);

    // R5 chain mode
    doWrite(2'd1, 32'd2);
    doWrite(2'd2, 32'd2);
    doWrite(2'd0, ctrlWord(1, 1, 0, 2'b01, 1));
    doPulse(0); doPulse(0);
    doRead(2'd1, rd); check("R5 reload", rd, 32'd2);
    doRead(2'd2, rd); check("R5 chain step", rd, 32'd1);
    check("R5 no flag mid chain", {31'd0, irqOut}, 32'd0);
    doPulse(0); doPulse(0);
    check("R5 flag after last link", {31'd0, irqOut}, 32'd1);

    // R11 unmapped address
    doRead(2'd3, rd); check("R11 unmapped reads zero", rd, 32'h0);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int op;
      op = $urandom_range(0, 19);
      if (op < 3) begin
        logic [1:0] sz;
        sz = ($urandom_range(0, 7) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
        doWrite(2'd0, ctrlWord(1'($urandom_range(0, 3) != 0), 1'($urandom),
                               1'($urandom), sz, 1'($urandom)));
      end else if (op < 5) doWrite(2'd1, 32'($urandom_range(0, 4)));
      else if (op < 6) doWrite(2'd2, 32'($urandom_range(0, 3)));
      else if (op < 10) begin
        logic [1:0] a;
        logic [31:0] ex;
        a = 2'($urandom_range(0, 3));
        ex = expRead(a);
        doRead(a, rd);
        check("R11 random read", rd, ex);
      end else if (op < 16) doPulse(0);
      else if (op < 17) doPulse(1);
      else if (op < 18) begin masterEn = ~masterEn; @(negedge clk); end
      else if (op < 19) begin modStandby = ($urandom_range(0, 3) == 0); @(negedge clk); end
      else doStandby();
      checkOuts("R2 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule